// File: doc/BRIEF.md
# Single-Wire Receive Conditioner and Echo Checker

This block sits between the receive pin of a single-wire serial port (such as LIN) and the port's byte logic. It first synchronizes the raw receive line. It then passes the line through a digital deglitcher, which ignores any level change shorter than sixteen prescaled clock periods. The prescale divide can be set from 1 to 8, so the shortest accepted pulse ranges from 16 to 128 module clocks. The highest usable bit rate is the reciprocal of that width.

While the port transmits, the block also compares each driven bit with its echo on the filtered receive line. The comparison is taken late in the bit, at seven eighths of the bit period counted from the bit's start strobe. This lets a slow physical layer lag the driven bit by a large part of a bit time without a false alarm. A mismatch sets a sticky error flag, which stays set until it is cleared. The comparison can be switched off for links whose delay is too long to check reliably. Byte framing, break detection and baud generation belong to other blocks.

Top module: `lin_rx_guard`

## Requirements
- R1: While reset is asserted, `rxFilt` is 1 whatever `rxRaw` does, and `bitErr` is 0. All internal counters restart.
- R2: The divide is `preSel`+1, so a value of 0 to 7 gives a divide of 1 to 8. A level on `rxRaw` that differs from `rxFilt` for at least 16×divide consecutive cycles, after the two-stage synchronizer, is copied to `rxFilt`. This holds for both polarities.
- R3: A pulse shorter than 16×divide cycles leaves `rxFilt` unchanged. Any return to the current `rxFilt` level restarts the count, so two short pulses separated by one cycle are also rejected.
- R4: Filter latency is fixed. If `rxRaw` changes before clock edge E1 and holds for 16×divide cycles, `rxFilt` takes the new value after edge E(2+16×divide) and not before.
- R5: The sample index is floor(7×`bitTicks`/8). It is taken in the cycle whose counter value equals that index, where the counter restarts at 0 on the edge that samples `txBitStart`=1. A resulting error is visible on `bitErr` one edge later. There is one sample per strobe.
- R6: The sample compares `rxFilt` with the `txBit` value captured on the start edge. No error is flagged when the echo's filtered copy has updated by the sample cycle. With `bitTicks`=64 and divide 1, this is the case for a pin-level echo lag of 0 to 39 cycles.
- R7: If `rxFilt` differs from the captured bit at the sample, with `chkEn`=1, `bitErr` is set. Examples are an inverted echo, or a lag of 40 cycles or more under the R6 settings.
- R8: With `chkEn`=0, a mismatch at the sample point never sets `bitErr`.
- R9: `bitErr` stays set until `errClr` is 1 for a cycle. If a clear and a new error fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxRaw | input | 1 | Raw receive line, asynchronous |
| txBit | input | 1 | Bit currently driven on the transmit line |
| txBitStart | input | 1 | One-cycle strobe at the start of each transmitted bit |
| bitTicks | input | TICK_W (16) | Bit period in module clocks |
| preSel | input | PRE_W (3) | Filter prescale select; divide = value + 1 |
| chkEn | input | 1 | Enables the echo comparison |
| errClr | input | 1 | Clears the bit-error flag |
| rxFilt | output | 1 | Deglitched receive line, idles high |
| bitErr | output | 1 | Sticky echo-mismatch flag |

## Verification
Each result has a fixed arrival time, and every check is sampled on the falling clock edge at that time.

A level change on `rxRaw` reaches `rxFilt` 2+16×divide rising edges after it is first sampled. The filter sweep checks the output one edge before that point and again at that edge, for every divide from 1 to 8. Rejected pulses are judged after a wait longer than any acceptance latency.

An echo error appears on `bitErr` floor(7×`bitTicks`/8)+1 edges after the start edge. The timing test reads the flag one edge before and at that edge for three bit periods, and asserts a clear on exactly the setting edge. The echo-lag sweep predicts pass or fail from the cycle-exact sum of the lag and the filter latency, compared against the sample index.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

  // Strobes from the control path to the datapath, valid for one cycle.
  typedef struct packed {
    logic preTick;    // one prescaled period of mismatch has elapsed
    logic latchTx;    // capture the transmitted bit (start of bit)
    logic sampleNow;  // compare echo with captured bit this cycle
  } ctlStrobe_t;

endpackage

// File: rtl/lin_rx_ctrl.sv
module lin_rx_ctrl
  import lin_rx_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PRE_W-1:0]  preSel,
  input  logic [TICK_W-1:0] bitTicks,
  input  logic              txBitStart,
  input  logic              lvlDiffer,
  output ctlStrobe_t        strobes
);

  localparam int PROD_W = TICK_W + 3;

  logic [PRE_W-1:0]  preCnt;
  logic [TICK_W-1:0] bitCnt;
  logic              armed;
  logic [PROD_W-1:0] prod7;
  logic [TICK_W-1:0] samplePt;
  logic              preTick;
  logic              sampleNow;

  // Sample index = floor(7 * bitTicks / 8), computed without a multiplier.
  always_comb begin
    prod7    = ({3'b000, bitTicks} << 3) - {3'b000, bitTicks};
    samplePt = prod7[PROD_W-1:3];
  end

  // Prescaler: runs only while the synchronized line disagrees with the
  // filtered output, so each acceptance window starts at a known phase.
  assign preTick = lvlDiffer && (preCnt == preSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!lvlDiffer || preTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // Bit-position counter: restarts on each start strobe, fires once.
  assign sampleNow = armed && !txBitStart && (bitCnt == samplePt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      bitCnt <= '0;
    end else if (txBitStart) begin
      armed  <= 1'b1;
      bitCnt <= '0;
    end else if (armed) begin
      if (sampleNow) begin
        armed <= 1'b0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.preTick   = preTick;
    strobes.latchTx   = txBitStart;
    strobes.sampleNow = sampleNow;
  end

endmodule

// File: rtl/lin_rx_datapath.sv
module lin_rx_datapath
  import lin_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxRaw,
  input  logic       txBit,
  input  logic       chkEn,
  input  logic       errClr,
  input  ctlStrobe_t strobes,
  output logic       lvlDiffer,
  output logic       rxSync,
  output logic       rxFilt,
  output logic       bitErr
);

  localparam int FC_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FC_W-1:0]        filtCnt;
  logic                   txHeld;
  logic                   echoBad;

  // Synchronizer chain, resets to the recessive level.
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
    if (i == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= rxRaw;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign rxSync    = syncQ[SYNC_STAGES-1];
  assign lvlDiffer = (rxSync != rxFilt);

  // Deglitch counter: counts prescaled periods of steady disagreement.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtCnt <= '0;
      rxFilt  <= 1'b1;
    end else if (!lvlDiffer) begin
      filtCnt <= '0;
    end else if (strobes.preTick) begin
      if (filtCnt == FC_LAST) begin
        filtCnt <= '0;
        rxFilt  <= rxSync;
      end else begin
        filtCnt <= filtCnt + 1'b1;
      end
    end
  end

  // Captured transmit bit for the echo comparison.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                txHeld <= 1'b1;
    else if (strobes.latchTx) txHeld <= txBit;
  end

  assign echoBad = strobes.sampleNow && chkEn && (rxFilt != txHeld);

  // Sticky flag; a new error outranks a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        bitErr <= 1'b0;
    else if (echoBad) bitErr <= 1'b1;
    else if (errClr)  bitErr <= 1'b0;
  end

endmodule

// File: rtl/lin_rx_guard.sv
module lin_rx_guard
  import lin_rx_pkg::*;
#(
  parameter int PRE_W       = 3,
  parameter int TICK_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxRaw,
  input  logic              txBit,
  input  logic              txBitStart,
  input  logic [TICK_W-1:0] bitTicks,
  input  logic [PRE_W-1:0]  preSel,
  input  logic              chkEn,
  input  logic              errClr,
  output logic              rxFilt,
  output logic              bitErr
);

  ctlStrobe_t ctlBus;
  logic       lvlDiffer;
  logic       syncTap;
  logic       sampleTap;

  lin_rx_ctrl #(
    .PRE_W (PRE_W),
    .TICK_W(TICK_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .preSel    (preSel),
    .bitTicks  (bitTicks),
    .txBitStart(txBitStart),
    .lvlDiffer (lvlDiffer),
    .strobes   (ctlBus)
  );

  lin_rx_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .rxRaw    (rxRaw),
    .txBit    (txBit),
    .chkEn    (chkEn),
    .errClr   (errClr),
    .strobes  (ctlBus),
    .lvlDiffer(lvlDiffer),
    .rxSync   (syncTap),
    .rxFilt   (rxFilt),
    .bitErr   (bitErr)
  );

  assign sampleTap = ctlBus.sampleNow;

endmodule

// File: rtl/lin_rx_guard_chk.sv
module lin_rx_guard_chk (
  input logic clk,
  input logic rstN,
  input logic rxFilt,
  input logic bitErr,
  input logic errClr,
  input logic chkEn,
  input logic rxSync,
  input logic sampleNow
);

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (rxFilt && !bitErr)); // R1

  AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxFilt) |-> (rxFilt == $past(rxSync))); // R2

  AST_SET_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bitErr) |-> $past(sampleNow)); // R5

  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!chkEn && !bitErr) |=> !bitErr); // R8

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (bitErr && !errClr) |=> bitErr); // R9

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !sampleNow) |=> !bitErr); // R9

endmodule

bind lin_rx_guard lin_rx_guard_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .rxFilt   (rxFilt),
  .bitErr   (bitErr),
  .errClr   (errClr),
  .chkEn    (chkEn),
  .rxSync   (syncTap),
  .sampleNow(sampleTap)
);

// File: tb/lin_rx_guard_test.sv
module lin_rx_guard_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rxRaw;
  logic        txBit;
  logic        txBitStart;
  logic [15:0] bitTicks;
  logic [2:0]  preSel;
  logic        chkEn;
  logic        errClr;
  logic        rxFilt;
  logic        bitErr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  lin_rx_guard uut (
    .clk       (clk),
    .rstN      (rstN),
    .rxRaw     (rxRaw),
    .txBit     (txBit),
    .txBitStart(txBitStart),
    .bitTicks  (bitTicks),
    .preSel    (preSel),
    .chkEn     (chkEn),
    .errClr    (errClr),
    .rxFilt    (rxFilt),
    .bitErr    (bitErr)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected < 150000", cycles);
      summary();
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // Pass n rising edges, then stop on the following falling edge.
  task automatic stepTo(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // One filter configuration: divide d.
  task automatic filterSweep(int d);
    int w = 16 * d;
    preSel = 3'(d - 1);
    rxRaw  = 1'b1;
    stepTo(w + 10);
    // R3: low glitch one cycle short
    rxRaw = 1'b0; stepTo(w - 1);
    rxRaw = 1'b1; stepTo(w + 10);
    chk("R3 short low pulse", rxFilt, 1'b1);
    // R3: two short pulses split by one high cycle
    rxRaw = 1'b0; stepTo(w - 1);
    rxRaw = 1'b1; stepTo(1);
    rxRaw = 1'b0; stepTo(w - 1);
    rxRaw = 1'b1; stepTo(w + 10);
    chk("R3 split pulses", rxFilt, 1'b1);
    // R2/R4: exactly the minimum width passes, on a fixed edge
    rxRaw = 1'b0; stepTo(w);
    rxRaw = 1'b1; stepTo(1);
    chk("R4 one edge early", rxFilt, 1'b1);
    stepTo(1);
    chk("R2 min low pulse accepted", rxFilt, 1'b0);
    stepTo(w + 10);
    chk("R2 return high", rxFilt, 1'b1);
    // R3: high glitch while low
    rxRaw = 1'b0; stepTo(w + 10);
    chk("R2 held low", rxFilt, 1'b0);
    rxRaw = 1'b1; stepTo(w - 1);
    rxRaw = 1'b0; stepTo(w + 10);
    chk("R3 short high pulse", rxFilt, 1'b0);
    rxRaw = 1'b1; stepTo(w + 10);
    chk("R2 back high", rxFilt, 1'b1);
  endtask

  // Echo trial: four alternating bits, echo lagging by lag cycles.
  task automatic echoTrial(int lag, logic inv, logic en, logic expErr, string req);
    logic [63:0] hist;
    preSel   = 3'd0;
    bitTicks = 16'd64;
    txBit    = 1'b1;
    rxRaw    = 1'b1 ^ inv;
    chkEn    = en;
    stepTo(40);
    errClr = 1'b1; stepTo(1);
    errClr = 1'b0;
    hist = '1;
    for (int c = 0; c < 4 * 64 + 40; c++) begin
      txBitStart = (c % 64 == 0) && (c < 256);
      if (txBitStart) txBit = ((c / 64) % 2 == 0) ? 1'b0 : 1'b1;
      hist  = {hist[62:0], txBit};
      rxRaw = hist[lag] ^ inv;
      stepTo(1);
    end
    txBitStart = 1'b0;
    chk(req, bitErr, expErr);
  endtask

  // Sample timing and clear priority for one bit period.
  task automatic timingTest(int bt);
    int sp = (7 * bt) / 8;
    preSel   = 3'd0;
    bitTicks = 16'(bt);
    chkEn    = 1'b1;
    rxRaw    = 1'b1;
    txBit    = 1'b1;
    stepTo(40);
    errClr = 1'b1; stepTo(1);
    errClr = 1'b0;
    txBitStart = 1'b1; txBit = 1'b0;
    stepTo(0);
    txBitStart = 1'b0;
    stepTo(sp);
    chk("R5 no flag before sample", bitErr, 1'b0);
    errClr = 1'b1;
    stepTo(1);
    chk("R9 set wins over clear", bitErr, 1'b1);
    errClr = 1'b0;
    stepTo(5);
    chk("R9 flag sticky", bitErr, 1'b1);
    errClr = 1'b1; stepTo(1);
    errClr = 1'b0;
    chk("R9 clear", bitErr, 1'b0);
    txBit = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; rxRaw = 1'b0; txBit = 1'b1; txBitStart = 1'b0;
    bitTicks = 16'd64; preSel = 3'd0; chkEn = 1'b1; errClr = 1'b0;
    stepTo(30);
    chk("R1 rxFilt high in reset", rxFilt, 1'b1);
    chk("R1 flag clear in reset", bitErr, 1'b0);
    rxRaw = 1'b1;
    stepTo(3);
    rstN = 1'b1;
    stepTo(3);
    chk("R1 rxFilt after reset", rxFilt, 1'b1);

    for (int d = 1; d <= 8; d++) filterSweep(d);

    for (int lag = 0; lag <= 50; lag++) begin
      if (lag >= 40) echoTrial(lag, 1'b0, 1'b1, 1'b1, "R7 late echo");
      else           echoTrial(lag, 1'b0, 1'b1, 1'b0, "R6 tolerated lag");
    end
    echoTrial(0, 1'b1, 1'b1, 1'b1, "R7 inverted echo");
    echoTrial(45, 1'b0, 1'b0, 1'b0, "R8 disabled late echo");
    echoTrial(0, 1'b1, 1'b0, 1'b0, "R8 disabled inverted echo");

    timingTest(20);
    timingTest(64);
    timingTest(100);

    summary();
  end

endmodule